// File: doc/BRIEF.md
# IQ Sample Width Gearbox with Bypass

This block adapts a stream of IQ sample words to a fixed 128-bit output word. A runtime width setting chooses between two paths. In packed mode each input beat carries eight 12-bit samples in its low 96 bits. The gearbox concatenates these 96-bit slices without gaps into full 128-bit words. In wide mode each input beat already holds eight 16-bit samples and is forwarded as it is.

An input demultiplexer steers beats to the active path, and an output multiplexer chooses which path feeds a 16-word output FIFO. Both the sample side and the word side use valid/ready handshakes. Input ready is withdrawn only when the beat offered would complete a word that the FIFO cannot take. The width setting is meant to change only while no beat is offered. Any switch discards the partial word held in the gearbox.

Top module: `sample_gearbox_top`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1.
- R2: With `pack_12b`=1, the low 96 bits of successive accepted beats are concatenated least significant first. Beats b0..b3 yield exactly three words: {b1[31:0],b0[95:0]}, {b2[63:0],b1[95:32]} and {b3[95:0],b2[95:64]}. The pattern then restarts with nothing left over.
- R3: With `pack_12b`=1, input bits 127:96 have no effect on any output word.
- R4: With `pack_12b`=0, every accepted beat appears as exactly one output word, equal to all 128 input bits.
- R5: `pack_12b`=1 selects the packing path and `pack_12b`=0 selects the bypass path.
- R6: Any change of `pack_12b` discards the partially filled word. Words formed afterwards contain only beats accepted after the change.
- R7: Output words leave in the order they were formed. Up to 16 words are held. In bypass mode `s_ready` is 0 while 16 words are held.
- R8: In packing mode with 16 words held, a beat that completes no word is still accepted, while a beat that would complete a word sees `s_ready`=0.
- R9: While `m_valid`=1 and `m_ready`=0, `m_valid` stays 1 and `m_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pack_12b | input | 1 | Width setting: 1 = 12-bit packing, 0 = 16-bit bypass |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with `s_valid` |
| s_data | input | 128 | Input beat |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts the output word |
| m_data | output | 128 | Output word |

## Verification
Two functions can coincide in the same cycle. The gearbox may absorb a beat into its residue while the FIFO is full and the downstream side is stalled. The testbench sets this up by parking one bypass word in the FIFO and then packing twenty beats. The FIFO then holds 16 words and the gearbox is empty. The bench checks that the next beat is still taken and that the one after it is held off. After draining, every word is compared with a bit-accumulator model, so a beat dropped or duplicated in that cycle shows up as a data mismatch.

// File: rtl/sgb_pkg.sv
package sgb_pkg;

   typedef enum logic {
      SGB_WIDE   = 1'b0,
      SGB_PACKED = 1'b1
   } sgb_mode_e;

endpackage

// File: rtl/sgb_packer.sv
module sgb_packer #(
   parameter int SLOT_W = 96,
   parameter int WORD_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [SLOT_W-1:0] in_slot,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word
);

   localparam int FILL_W = $clog2(WORD_W);
   localparam int ACC_W  = WORD_W + SLOT_W;
   localparam int SUM_W  = FILL_W + 1;

   if (SLOT_W >= WORD_W) begin : g_bad_slot
      $error("sgb_packer: SLOT_W must be narrower than WORD_W");
   end
   if (SLOT_W < 1) begin : g_bad_slot_min
      $error("sgb_packer: SLOT_W must be positive");
   end

   logic              active_q;
   logic [FILL_W-1:0] fill_q;
   logic [WORD_W-1:0] res_q;
   logic              switched;
   logic [FILL_W-1:0] fill_eff;
   logic [WORD_W-1:0] res_eff;
   logic [ACC_W-1:0]  joined;
   logic [SUM_W-1:0]  total;
   logic              completes;
   logic              fire;

   assign switched  = (active != active_q);
   assign fill_eff  = switched ? '0 : fill_q;
   assign res_eff   = switched ? '0 : res_q;
   assign joined    = ACC_W'(res_eff) | (ACC_W'(in_slot) << fill_eff);
   assign total     = SUM_W'(fill_eff) + SUM_W'(SLOT_W);
   assign completes = (total >= SUM_W'(WORD_W));

   assign in_ready  = !completes || out_ready;
   assign out_valid = in_valid && completes;
   assign out_word  = joined[WORD_W-1:0];
   assign fire      = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         fill_q   <= '0;
         res_q    <= '0;
      end else begin
         active_q <= active;
         if (fire) begin
            if (completes) begin
               res_q  <= WORD_W'(joined[ACC_W-1:WORD_W]);
               fill_q <= FILL_W'(total - SUM_W'(WORD_W));
            end else begin
               res_q  <= joined[WORD_W-1:0];
               fill_q <= FILL_W'(total);
            end
         end else if (switched) begin
            res_q  <= '0;
            fill_q <= '0;
         end
      end
   end

   AST_CLEAR_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (switched && !fire) |=> (fill_q == '0)) else $error("residue kept"); // R6

   AST_WORD_EMPTIES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && completes && (fill_eff == FILL_W'(WORD_W - SLOT_W))) |=> (fill_q == '0))
      else $error("group did not close"); // R2

endmodule

// File: rtl/sgb_fifo.sv
module sgb_fifo #(
   parameter int DATA_W = 128,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   output logic              push_ready,
   input  logic [DATA_W-1:0] push_data,
   output logic              pop_valid,
   input  logic              pop_ready,
   output logic [DATA_W-1:0] pop_data
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("sgb_fifo: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]     count;
   logic              full, empty, do_push, do_pop;

   assign full       = (count == CW'(DEPTH));
   assign empty      = (count == '0);
   assign push_ready = !full;
   assign pop_valid  = !empty;
   assign pop_data   = mem[rd_ptr];
   assign do_push    = push_valid && !full;
   assign do_pop     = pop_ready && !empty;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)) else $error("occupancy out of range"); // R7

   AST_PUSH_POP_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (do_push && do_pop) |=> $stable(count)) else $error("count moved"); // R7

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data)))
      else $error("output changed while stalled"); // R9

endmodule

// File: rtl/sgb_path_sel.sv
module sgb_path_sel
   import sgb_pkg::*;
#(
   parameter int BEAT_W = 128,
   parameter int SLOT_W = 96
) (
   input  sgb_mode_e         mode,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [BEAT_W-1:0] s_data,
   output logic              pk_valid,
   input  logic              pk_ready,
   output logic [SLOT_W-1:0] pk_slot,
   input  logic              pk_out_valid,
   input  logic [BEAT_W-1:0] pk_out_word,
   output logic              q_valid,
   input  logic              q_ready,
   output logic [BEAT_W-1:0] q_data
);

   logic is_packed;
   assign is_packed = (mode == SGB_PACKED);

   assign pk_valid = s_valid && is_packed;
   assign pk_slot  = s_data[SLOT_W-1:0];

   always_comb begin
      if (is_packed) begin
         q_valid = pk_out_valid;
         q_data  = pk_out_word;
         s_ready = pk_ready;
      end else begin
         q_valid = s_valid;
         q_data  = s_data;
         s_ready = q_ready;
      end
   end

endmodule

// File: rtl/sample_gearbox_top.sv
module sample_gearbox_top
   import sgb_pkg::*;
#(
   parameter int WORD_W     = 128,
   parameter int SLOT_W     = 96,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pack_12b,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [WORD_W-1:0] s_data,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [WORD_W-1:0] m_data
);

   if (SLOT_W > WORD_W) begin : g_bad_width
      $error("sample_gearbox_top: SLOT_W exceeds WORD_W");
   end

   sgb_mode_e         mode;
   logic              pk_valid, pk_ready, pk_out_valid;
   logic [SLOT_W-1:0] pk_slot;
   logic [WORD_W-1:0] pk_out_word;
   logic              q_valid, q_ready;
   logic [WORD_W-1:0] q_data;

   assign mode = sgb_mode_e'(pack_12b);

   sgb_path_sel #(
      .BEAT_W (WORD_W),
      .SLOT_W (SLOT_W)
   ) u_sel (
      .mode         (mode),
      .s_valid      (s_valid),
      .s_ready      (s_ready),
      .s_data       (s_data),
      .pk_valid     (pk_valid),
      .pk_ready     (pk_ready),
      .pk_slot      (pk_slot),
      .pk_out_valid (pk_out_valid),
      .pk_out_word  (pk_out_word),
      .q_valid      (q_valid),
      .q_ready      (q_ready),
      .q_data       (q_data)
   );

   sgb_packer #(
      .SLOT_W (SLOT_W),
      .WORD_W (WORD_W)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (pack_12b),
      .in_valid  (pk_valid),
      .in_ready  (pk_ready),
      .in_slot   (pk_slot),
      .out_valid (pk_out_valid),
      .out_ready (q_ready),
      .out_word  (pk_out_word)
   );

   sgb_fifo #(
      .DATA_W (WORD_W),
      .DEPTH  (FIFO_DEPTH)
   ) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (q_valid),
      .push_ready (q_ready),
      .push_data  (q_data),
      .pop_valid  (m_valid),
      .pop_ready  (m_ready),
      .pop_data   (m_data)
   );

   AST_STALL_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && !s_ready) |-> !q_ready) else $error("stall without full buffer"); // R8

   AST_BYPASS_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pack_12b && s_valid && s_ready) |=> m_valid) else $error("bypass beat lost"); // R4

endmodule

// File: tb/sample_gearbox_top_tb.sv
module sample_gearbox_top_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pack_12b = 1'b0;
   logic         s_valid = 1'b0;
   logic         s_ready;
   logic [127:0] s_data = '0;
   logic         m_valid;
   logic         m_ready = 1'b0;
   logic [127:0] m_data;

   int n_checks = 0;
   int n_fail   = 0;
   logic [127:0] expq [$];
   logic [255:0] acc;
   int           acc_bits;

   always #4 clk = ~clk;

   sample_gearbox_top u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pack_12b (pack_12b),
      .s_valid  (s_valid),
      .s_ready  (s_ready),
      .s_data   (s_data),
      .m_valid  (m_valid),
      .m_ready  (m_ready),
      .m_data   (m_data)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic model_clear();
      acc = '0;
      acc_bits = 0;
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk);
      pack_12b = m;
      model_clear();
      @(negedge clk);
   endtask

   task automatic send(input logic [127:0] d);
      s_data  = d;
      s_valid = 1'b1;
      forever begin
         #1;
         if (s_ready) begin
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
      @(negedge clk);
      s_valid = 1'b0;
      if (pack_12b) begin
         acc = acc | (256'(d[95:0]) << acc_bits);
         acc_bits += 96;
         if (acc_bits >= 128) begin
            expq.push_back(acc[127:0]);
            acc = acc >> 128;
            acc_bits -= 128;
         end
      end else begin
         expq.push_back(d);
      end
   endtask

   task automatic drain(input string req, input int n);
      int got = 0;
      int guard = 0;
      m_ready = 1'b1;
      while (got < n && guard < 200) begin
         #1;
         if (m_valid) begin
            check(req, m_data, expq.pop_front());
            got++;
         end
         @(posedge clk);
         @(negedge clk);
         guard++;
      end
      m_ready = 1'b0;
      if (got < n) check({req, " word count"}, 128'(got), 128'(n));
   endtask

   task automatic t_reset();
      check("R1 m_valid", 128'(m_valid), 128'(0));
      check("R1 s_ready", 128'(s_ready), 128'(1));
   endtask

   task automatic t_pack();
      set_mode(1'b1);
      send(rnd128());
      check("R2 no word after first beat", 128'(m_valid), 128'(0));
      for (int i = 0; i < 11; i++) send(rnd128());
      drain("R2 R3 R5 packed word", 9);
      check("R2 nothing left over", 128'(m_valid), 128'(0));
   endtask

   task automatic t_bypass();
      set_mode(1'b0);
      for (int i = 0; i < 5; i++) send(rnd128());
      drain("R4 R5 bypass word", 5);
   endtask

   task automatic t_switch();
      set_mode(1'b1);
      send(rnd128());
      set_mode(1'b0);
      set_mode(1'b1);
      for (int i = 0; i < 4; i++) send(rnd128());
      drain("R6 word after switch", 3);
      #1 check("R6 no stale word", 128'(m_valid), 128'(0));
   endtask

   task automatic t_full_bypass();
      logic [127:0] held;
      set_mode(1'b0);
      for (int i = 0; i < 16; i++) send(rnd128());
      #1;
      check("R7 s_ready low when full", 128'(s_ready), 128'(0));
      held = m_data;
      @(posedge clk); @(posedge clk); @(negedge clk); #1;
      check("R9 m_valid held", 128'(m_valid), 128'(1));
      check("R9 m_data held", m_data, held);
      drain("R7 order", 16);
   endtask

   task automatic t_full_pack();
      set_mode(1'b0);
      send(rnd128());
      set_mode(1'b1);
      for (int i = 0; i < 20; i++) send(rnd128());
      #1;
      check("R8 absorbing beat ready while full", 128'(s_ready), 128'(1));
      send(rnd128());
      #1;
      check("R8 completing beat held off", 128'(s_ready), 128'(0));
      drain("R8 full buffer word", 16);
      for (int i = 0; i < 3; i++) send(rnd128());
      drain("R8 word after release", 3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_pack();
      t_bypass();
      t_switch();
      t_full_bypass();
      t_full_pack();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule